// File: doc/BRIEF.md
# Delay-Slot Next-Next-PC Resolver

This block sits in the execute stage of a 32-bit RISC pipeline that has one branch delay slot. A control transfer placed in this stage decides the address of the instruction that follows its delay slot, so the block works out the next-next program counter. Its inputs are the current PC, the already-fetched next PC (the delay-slot address), the raw instruction word, a decoded control class, a link request, the evaluated branch condition and one source register value.

The block returns the next-next PC as a combinational result in the same cycle. It also raises a write request for the return-address register (register 31), whose value is the address just past the delay slot. It produces a registered annul pulse that lines up with the delay-slot instruction one cycle later. The annul pulse fires only for a branch-likely instruction whose condition is false. Decode, condition evaluation, register file access and fetch happen outside the block.

Top module: `bu_nnpc_top`

## Requirements
- R1: The control class input `ctl_class` uses these codes: 0 = not a control transfer, 1 = conditional branch, 2 = branch-likely, 3 = absolute jump, 4 = register-indirect jump. Codes 5 to 7 are treated as code 0.
- R2: The branch displacement is instruction bits [15:0] shifted left by two and sign-extended from bit 17. The largest positive field 0x7FFF gives +0x1FFFC, and 0x8000 gives 0xFFFE0000.
- R3: For class 1 or 2 with `cond_true` high, `nn_pc` equals `nxt_pc` plus the displacement. This is the same value as `cur_pc` + 4 + displacement.
- R4: For class 1 or 2 with `cond_true` low, `nn_pc` equals `nxt_pc` + 4.
- R5: For class 3, `nn_pc` holds bits [31:28] of `cur_pc` + 4. Bits [27:2] hold instruction bits [25:0], and bits [1:0] are zero. This holds with or without link.
- R6: For class 4, `nn_pc` equals `src_val` with bits [1:0] cleared, ORed with bit 0 of `nxt_pc`.
- R7: When `ins_valid` and `link_en` are high and the class is 1 to 4, `ra_we` is high and `ra_val` equals `cur_pc` + 8. This holds whether or not a branch is taken. In every other case `ra_we` is low.
- R8: For classes 0 and 5 to 7, `nn_pc` equals `nxt_pc` + 4 and `ra_we` stays low.
- R9: `slot_annul` is high for exactly the one cycle after a valid class-2 instruction with `cond_true` low was presented, so that it lines up with the delay-slot instruction.
- R10: `slot_annul` is never raised after a conditional branch, a jump, a non-control instruction, a taken branch-likely or an invalid slot.
- R11: All address sums wrap modulo 2^32.
- R12: While `rst_n` is low and in the first cycle after reset, `slot_annul` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | A real instruction occupies the stage |
| cur_pc | input | 32 | Address of the instruction in the stage |
| nxt_pc | input | 32 | Address of its delay slot |
| ins_word | input | 32 | Raw instruction word |
| ctl_class | input | 3 | Decoded control class (see R1) |
| link_en | input | 1 | Instruction writes the return address |
| cond_true | input | 1 | Evaluated branch condition |
| src_val | input | 32 | Source register value for indirect jumps |
| nn_pc | output | 32 | Next-next program counter |
| ra_we | output | 1 | Return-address register write enable |
| ra_val | output | 32 | Return address value |
| slot_annul | output | 1 | Squash the delay-slot instruction |

## Verification
The bench applies the extreme offsets 0x7FFF and 0x8000. A design that extends the sign from bit 15, or forgets the shift, sends those branches to the wrong region. It places branches and sequential flow next to 0xFFFFFFFC and 0x00000000, where an adder that is too narrow or saturating gives a non-wrapped address. It mixes taken and not-taken branch-likely instructions with ordinary branches. A slip there shows up as an annul pulse after a plain branch or a taken one, or as the pulse arriving a cycle off. Indirect jumps use odd register values and odd next PCs, which catches a jump that keeps the low register bits or drops the mode bit from the next PC.

// File: rtl/bu_nnpc_pkg.sv
package bu_nnpc_pkg;
   typedef enum logic [2:0] {
      CC_NONE   = 3'd0,
      CC_BRANCH = 3'd1,
      CC_LIKELY = 3'd2,
      CC_JABS   = 3'd3,
      CC_JREG   = 3'd4
   } ctl_class_e;

   localparam int unsigned CLS_W = 3;

   function automatic logic is_pcrel(input logic [CLS_W-1:0] c);
      return (c == CC_BRANCH) || (c == CC_LIKELY);
   endfunction

   function automatic logic is_ctl(input logic [CLS_W-1:0] c);
      return (c >= CC_BRANCH) && (c <= CC_JREG);
   endfunction
endpackage

// File: rtl/bu_disp_ext.sv
module bu_disp_ext #(
   parameter int unsigned AW    = 32,
   parameter int unsigned OFF_W = 16
) (
   input  logic [OFF_W-1:0] off_field,
   output logic [AW-1:0]    disp
);
   localparam int unsigned SH_W = OFF_W + 2;

   generate
      if (SH_W > AW) begin : g_bad
         $error("offset field too wide for address width");
      end
      if (SH_W == AW) begin : g_exact
         assign disp = {off_field, 2'b00};
      end else begin : g_ext
         assign disp = {{(AW-SH_W){off_field[OFF_W-1]}}, off_field, 2'b00};
      end
   endgenerate
endmodule

// File: rtl/bu_target.sv
module bu_target #(
   parameter int unsigned AW       = 32,
   parameter int unsigned JIDX_W   = 26,
   parameter bit          KEEP_LSB = 1'b1
) (
   input  logic [AW-1:0]     cur_pc,
   input  logic [AW-1:0]     nxt_pc,
   input  logic [AW-1:0]     disp,
   input  logic [JIDX_W-1:0] jidx,
   input  logic [AW-1:0]     src_val,
   output logic [AW-1:0]     seq_tgt,
   output logic [AW-1:0]     rel_tgt,
   output logic [AW-1:0]     abs_tgt,
   output logic [AW-1:0]     reg_tgt,
   output logic [AW-1:0]     link_val
);
   localparam int unsigned HI_W = AW - JIDX_W - 2;

   logic [AW-1:0] pc_plus4;

   assign pc_plus4 = cur_pc + AW'(4);
   assign seq_tgt  = nxt_pc + AW'(4);
   assign rel_tgt  = nxt_pc + disp;
   assign link_val = cur_pc + AW'(8);

   generate
      if (JIDX_W + 2 >= AW) begin : g_bad
         $error("jump index leaves no region bits");
      end else begin : g_abs
         assign abs_tgt = {pc_plus4[AW-1 -: HI_W], jidx, 2'b00};
      end

      if (KEEP_LSB) begin : g_keep
         assign reg_tgt = {src_val[AW-1:2], 1'b0, nxt_pc[0]};
      end else begin : g_clear
         assign reg_tgt = {src_val[AW-1:2], 2'b00};
      end
   endgenerate
endmodule

// File: rtl/bu_select.sv
module bu_select
   import bu_nnpc_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_valid,
   input  logic [CLS_W-1:0] ctl_class,
   input  logic             link_en,
   input  logic             cond_true,
   input  logic [AW-1:0]    seq_tgt,
   input  logic [AW-1:0]    rel_tgt,
   input  logic [AW-1:0]    abs_tgt,
   input  logic [AW-1:0]    reg_tgt,
   output logic [AW-1:0]    nn_pc,
   output logic             ra_we,
   output logic             slot_annul
);
   logic annul_q;

   always_comb begin
      unique case (ctl_class)
         CC_BRANCH, CC_LIKELY: nn_pc = cond_true ? rel_tgt : seq_tgt;
         CC_JABS:              nn_pc = abs_tgt;
         CC_JREG:              nn_pc = reg_tgt;
         default:              nn_pc = seq_tgt;
      endcase
   end

   assign ra_we = ins_valid & link_en & is_ctl(ctl_class);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         annul_q <= 1'b0;
      end else begin
         annul_q <= ins_valid & (ctl_class == CC_LIKELY) & ~cond_true;
      end
   end

   assign slot_annul = annul_q;
endmodule

// File: rtl/bu_nnpc_top.sv
module bu_nnpc_top
   import bu_nnpc_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned OFF_W    = 16,
   parameter int unsigned JIDX_W   = 26,
   parameter bit          KEEP_LSB = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ins_valid,
   input  logic [31:0]   cur_pc,
   input  logic [31:0]   nxt_pc,
   input  logic [31:0]   ins_word,
   input  logic [2:0]    ctl_class,
   input  logic          link_en,
   input  logic          cond_true,
   input  logic [31:0]   src_val,
   output logic [31:0]   nn_pc,
   output logic          ra_we,
   output logic [31:0]   ra_val,
   output logic          slot_annul
);
   generate
      if (AW != 32) begin : g_aw_chk
         $error("port list is fixed at 32 address bits");
      end
      if (OFF_W > JIDX_W) begin : g_fld_chk
         $error("offset field must fit inside jump index field");
      end
   endgenerate

   logic [AW-1:0] disp, seq_tgt, rel_tgt, abs_tgt, reg_tgt;
   logic          unused_hi;

   assign unused_hi = ^ins_word[AW-1:JIDX_W];

   bu_disp_ext #(.AW(AW), .OFF_W(OFF_W)) u_disp (
      .off_field (ins_word[OFF_W-1:0]),
      .disp      (disp)
   );

   bu_target #(.AW(AW), .JIDX_W(JIDX_W), .KEEP_LSB(KEEP_LSB)) u_tgt (
      .cur_pc   (cur_pc),
      .nxt_pc   (nxt_pc),
      .disp     (disp),
      .jidx     (ins_word[JIDX_W-1:0]),
      .src_val  (src_val),
      .seq_tgt  (seq_tgt),
      .rel_tgt  (rel_tgt),
      .abs_tgt  (abs_tgt),
      .reg_tgt  (reg_tgt),
      .link_val (ra_val)
   );

   bu_select #(.AW(AW)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .ins_valid  (ins_valid),
      .ctl_class  (ctl_class),
      .link_en    (link_en),
      .cond_true  (cond_true),
      .seq_tgt    (seq_tgt),
      .rel_tgt    (rel_tgt),
      .abs_tgt    (abs_tgt),
      .reg_tgt    (reg_tgt),
      .nn_pc      (nn_pc),
      .ra_we      (ra_we),
      .slot_annul (slot_annul)
   );
endmodule

// File: rtl/bu_nnpc_chk.sv
module bu_nnpc_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ins_valid,
   input logic [31:0] cur_pc,
   input logic [31:0] nxt_pc,
   input logic [2:0]  ctl_class,
   input logic        cond_true,
   input logic [31:0] src_val,
   input logic [31:0] nn_pc,
   input logic        ra_we,
   input logic [31:0] ra_val,
   input logic        slot_annul
);
   // R9: a squash pulse only follows a valid, not-taken branch-likely
   p_annul_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      slot_annul |-> $past(ins_valid && ctl_class == 3'd2 && !cond_true));

   // R10: a plain branch never squashes its slot
   p_no_annul_branch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_class == 3'd1) |=> !slot_annul);

   // R7: return address is always two words past the instruction
   p_link_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ra_we |-> (ra_val == cur_pc + 32'd8));

   // R8: non-control classes run sequentially without link
   p_seq_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_class == 3'd0) |-> (nn_pc == nxt_pc + 32'd4 && !ra_we));

   // R6: indirect target low bits come from the next PC, not the register
   p_jreg_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_class == 3'd4) |-> (nn_pc[1:0] == {1'b0, nxt_pc[0]}
                               && nn_pc[31:2] == src_val[31:2]));

   // R5: absolute jump keeps the region of PC plus 4
   p_jabs_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_class == 3'd3) |-> (nn_pc[31:28] == (cur_pc + 32'd4) >> 28
                               && nn_pc[1:0] == 2'b00));
endmodule

bind bu_nnpc_top bu_nnpc_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ins_valid  (ins_valid),
   .cur_pc     (cur_pc),
   .nxt_pc     (nxt_pc),
   .ctl_class  (ctl_class),
   .cond_true  (cond_true),
   .src_val    (src_val),
   .nn_pc      (nn_pc),
   .ra_we      (ra_we),
   .ra_val     (ra_val),
   .slot_annul (slot_annul)
);

// File: tb/test_bu_nnpc_top.sv
`timescale 1ns/1ps
module test_bu_nnpc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ins_valid = 1'b0;
   logic [31:0] cur_pc = '0, nxt_pc = '0, ins_word = '0, src_val = '0;
   logic [2:0]  ctl_class = '0;
   logic        link_en = 1'b0, cond_true = 1'b0;
   logic [31:0] nn_pc, ra_val;
   logic        ra_we, slot_annul;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   bu_nnpc_top i_bu_nnpc_top (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .cur_pc(cur_pc),
      .nxt_pc(nxt_pc), .ins_word(ins_word), .ctl_class(ctl_class),
      .link_en(link_en), .cond_true(cond_true), .src_val(src_val),
      .nn_pc(nn_pc), .ra_we(ra_we), .ra_val(ra_val), .slot_annul(slot_annul)
   );

   function automatic logic [31:0] exp_disp(input logic [15:0] f);
      return {{14{f[15]}}, f, 2'b00};
   endfunction

   function automatic logic [31:0] exp_nnpc(input logic [2:0] c, input logic t,
      input logic [31:0] pc, input logic [31:0] npc, input logic [31:0] w,
      input logic [31:0] rs);
      logic [31:0] p4;
      p4 = pc + 32'd4;
      case (c)
         3'd1, 3'd2: return t ? npc + exp_disp(w[15:0]) : npc + 32'd4;
         3'd3:       return {p4[31:28], w[25:0], 2'b00};
         3'd4:       return {rs[31:2], 1'b0, npc[0]};
         default:    return npc + 32'd4;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at negedge, check comb outputs, then the annul after next posedge
   task automatic apply(input string req, input logic v, input logic [2:0] c,
      input logic lk, input logic t, input logic [31:0] pc,
      input logic [31:0] npc, input logic [31:0] w, input logic [31:0] rs,
      input bit chk_pc);
      logic ea, ew;
      @(negedge clk);
      ins_valid = v; ctl_class = c; link_en = lk; cond_true = t;
      cur_pc = pc; nxt_pc = npc; ins_word = w; src_val = rs;
      #2;
      ew = v && lk && (c >= 3'd1) && (c <= 3'd4);
      if (chk_pc) check({req, " nn_pc"}, nn_pc, exp_nnpc(c, t, pc, npc, w, rs));
      check("R7 ra_we", {31'd0, ra_we}, {31'd0, ew});
      if (ew) check("R7 ra_val", ra_val, pc + 32'd8);
      ea = v && (c == 3'd2) && !t;
      @(posedge clk);
      #1;
      check(ea ? "R9 annul" : "R10 annul", {31'd0, slot_annul}, {31'd0, ea});
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (2) @(posedge clk);
      #1;
      check("R12 annul in reset", {31'd0, slot_annul}, 32'd0);
      // hold a not-taken likely at the input during reset: still no pulse
      ins_valid = 1'b1; ctl_class = 3'd2; cond_true = 1'b0;
      @(posedge clk); #1;
      check("R12 annul in reset", {31'd0, slot_annul}, 32'd0);
      @(negedge clk);
      ins_valid = 1'b0;
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R12 annul after reset", {31'd0, slot_annul}, 32'd0);

      // R2 R3: largest positive offset
      apply("R2", 1, 3'd1, 0, 1, 32'h0000_1000, 32'h0000_1004,
            32'h1000_7FFF, 0, 1);
      check("R2 max disp", nn_pc, 32'h0000_1004 + 32'h0001_FFFC);
      // R2: most negative offset
      apply("R2", 1, 3'd1, 0, 1, 32'h0010_0000, 32'h0010_0004,
            32'h1000_8000, 0, 1);
      check("R2 min disp", nn_pc, 32'h0010_0004 + 32'hFFFE_0000);
      // R11: backward branch wraps below zero
      apply("R11", 1, 3'd1, 0, 1, 32'h0000_0000, 32'h0000_0004,
            32'h0000_FFFE, 0, 1);
      check("R11 wrap down", nn_pc, 32'hFFFF_FFFC);
      // R11: sequential wraps past the top
      apply("R11", 1, 3'd0, 0, 0, 32'hFFFF_FFF8, 32'hFFFF_FFFC, 0, 0, 1);
      check("R11 wrap up", nn_pc, 32'h0000_0000);
      // R11: link value wraps
      apply("R11", 1, 3'd1, 1, 0, 32'hFFFF_FFFC, 32'h0000_0000, 0, 0, 1);
      check("R11 link wrap", ra_val, 32'h0000_0004);
      // R4 R9: not-taken likely then R10 taken likely right after
      apply("R9", 1, 3'd2, 0, 0, 32'h400, 32'h404, 32'h0000_0010, 0, 1);
      apply("R10", 1, 3'd2, 0, 1, 32'h408, 32'h40C, 32'h0000_0010, 0, 1);
      // R9: invalid not-taken likely gives no pulse
      apply("R9", 0, 3'd2, 1, 0, 32'h500, 32'h504, 0, 0, 1);
      // R5: absolute jump with region bits taken from PC+4 crossing
      apply("R5", 1, 3'd3, 1, 0, 32'h2FFF_FFFC, 32'h3000_0000,
            32'h03FF_FFFF, 0, 1);
      check("R5 region", nn_pc, 32'h3FFF_FFFC);
      // R6: odd register and odd next PC
      apply("R6", 1, 3'd4, 1, 0, 32'h800, 32'h805, 0, 32'hDEAD_BEEF, 1);
      check("R6 indirect", nn_pc, 32'hDEAD_BEED);
      // R1 R8: reserved class codes
      for (int k = 5; k < 8; k++)
         apply("R8", 1, 3'(k), 1, 1, 32'h900, 32'h904, 32'h0000_0004, 0, 1);

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] pc;
         logic [2:0]  c;
         pc = $urandom() & 32'hFFFF_FFFC;
         if (i % 16 == 0) pc = 32'hFFFF_FFF8;
         c  = 3'($urandom_range(0, 7));
         apply("R1 R3 R4", ($urandom_range(0, 7) != 0), c,
               1'($urandom()), 1'($urandom()), pc,
               pc + 32'd4 + 32'($urandom_range(0, 1)), $urandom(), $urandom(), 1);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule